// File: doc/BRIEF.md
# Centre-Aligned PWM Carrier with Synchronised Conversion Triggers

This block runs an up/down counter that forms a symmetric triangle carrier, derives a centre-aligned PWM output from it, and issues conversion-start pulses to an external converter at the top and/or bottom turning points of the carrier. When a switching converter runs in continuous conduction, its triangular ripple crosses its own average at exactly these turning points. A sample taken there is therefore the average value, and no digital filtering is needed afterwards.

The top count and the compare threshold are shadowed. New values take effect only when the counter reaches the bottom of the carrier, so every PWM pulse stays symmetric and the counter never climbs past a top value that has just been lowered. The converter reports a busy level. Any turning point that arrives while the converter is busy produces no trigger and is simply lost. Sampling therefore falls back into step on the first turning point after the conversion ends. A sticky flag records that a trigger was issued and is cleared by writing a one to its clear input.

Top module: `pwm_sync_trigger`

## Requirements
- R1: While reset is held and in the first cycle after it, `pwm_out`, `trig_pulse` and `trig_flag` are 0, and the counter sits at the bottom turning point.
- R2: With an active top count P, the counter climbs one step per cycle from 0 to P and then falls back to 0, so one carrier lasts 2·P cycles. A requested top count of 0 is treated as 1.
- R3: The counter never exceeds the active top count, including when a smaller top count is requested in the middle of a carrier.
- R4: `pwm_out` is 1 in exactly the cycles where the counter is below the active compare value, whether counting up or down. A compare value of 0 keeps it low, and a compare value above the top count keeps it high.
- R5: `cfg_period` and `cfg_compare` are sampled only in the cycle in which the counter is at the bottom turning point. Changes at any other time have no effect until then.
- R6: `cfg_sel` selects the trigger points: 2'b00 none, 2'b01 top only (bit 0 enables the top), 2'b10 bottom only (bit 1 enables the bottom), 2'b11 both. It acts without shadowing.
- R7: A selected turning point gives a `trig_pulse` of exactly one cycle, appearing in the cycle after the turning point.
- R8: A turning point that occurs while `conv_busy` is 1 gives no trigger. The next selected turning point that occurs with `conv_busy` at 0 does give one.
- R9: `trig_flag` becomes 1 together with each `trig_pulse` and stays 1 until `flag_clr` is 1 in a cycle. It then reads 0 in the next cycle, unless a trigger is issued at that same edge, in which case setting takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | W | Requested top count (shadowed) |
| cfg_compare | input | W | Requested PWM compare value (shadowed) |
| cfg_sel | input | 2 | Trigger point select |
| conv_busy | input | 1 | Converter busy level |
| flag_clr | input | 1 | Write-one-to-clear for the sticky flag |
| pwm_out | output | 1 | Centre-aligned PWM output |
| trig_pulse | output | 1 | One-cycle conversion-start pulse |
| trig_flag | output | 1 | Sticky trigger-issued flag |

## Verification
Two situations can land on the same clock edge. A trigger may be issued in the same cycle that software clears the flag, and a turning point may coincide with the converter still reporting busy. The first is provoked by holding `flag_clr` high continuously at a short top count, so that some clear cycles fall on trigger cycles; the flag must then read 1 after each trigger and 0 otherwise. The second is provoked by holding `conv_busy` across several turning points. No pulse may appear during that time, and a pulse is required at the first turning point after busy is released. Both are judged against a phase-indexed model of the carrier kept in the bench.

// File: rtl/pwmtrig_pkg.sv
package pwmtrig_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    SEL_OFF    = 2'b00,
    SEL_PEAK   = 2'b01,
    SEL_TROUGH = 2'b10,
    SEL_BOTH   = 2'b11
  } sel_e;

  // True when the selected mode asks for a trigger at the current turning point.
  function automatic logic wants_event(input sel_e s, input logic at_top, input logic at_bot);
    logic top_en;
    logic bot_en;
    top_en = (s == SEL_PEAK)   || (s == SEL_BOTH);
    bot_en = (s == SEL_TROUGH) || (s == SEL_BOTH);
    return (at_top && top_en) || (at_bot && bot_en);
  endfunction

endpackage

// File: rtl/pwmtrig_carrier.sv
module pwmtrig_carrier
  import pwmtrig_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_period,
  input  logic [W-1:0] cfg_compare,
  output logic [W-1:0] cnt,
  output logic [W-1:0] act_per,
  output logic [W-1:0] act_cmp,
  output logic         at_peak,
  output logic         at_trough
);

  localparam logic [W-1:0] ONE = W'(1);

  dir_e dir;

  // A top count of zero would freeze the carrier; the smallest usable one is 1.
  function automatic logic [W-1:0] eff_top(input logic [W-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  assign at_peak   = (dir == DIR_UP)   && (cnt >= act_per);
  assign at_trough = (dir == DIR_DOWN) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      dir     <= DIR_DOWN;
      act_per <= ONE;
      act_cmp <= '0;
    end else if (at_trough) begin
      act_per <= eff_top(cfg_period);
      act_cmp <= cfg_compare;
      cnt     <= ONE;
      dir     <= DIR_UP;
    end else if (at_peak) begin
      cnt <= cnt - ONE;
      dir <= DIR_DOWN;
    end else if (dir == DIR_UP) begin
      cnt <= cnt + ONE;
    end else begin
      cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/pwmtrig_compare.sv
module pwmtrig_compare #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] act_cmp,
  output logic         pwm_out
);

  function automatic logic below(input logic [W-1:0] c, input logic [W-1:0] thr);
    return c < thr;
  endfunction

  assign pwm_out = below(cnt, act_cmp);

endmodule

// File: rtl/pwmtrig_gate.sv
module pwmtrig_gate
  import pwmtrig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_sel,
  input  logic       conv_busy,
  input  logic       flag_clr,
  input  logic       at_peak,
  input  logic       at_trough,
  output logic       fire,
  output logic       trig_pulse,
  output logic       trig_flag
);

  assign fire = wants_event(sel_e'(cfg_sel), at_peak, at_trough) && !conv_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_pulse <= 1'b0;
      trig_flag  <= 1'b0;
    end else begin
      trig_pulse <= fire;
      trig_flag  <= fire || (trig_flag && !flag_clr);
    end
  end

endmodule

// File: rtl/pwm_sync_trigger.sv
module pwm_sync_trigger #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_period,
  input  logic [W-1:0] cfg_compare,
  input  logic [1:0]   cfg_sel,
  input  logic         conv_busy,
  input  logic         flag_clr,
  output logic         pwm_out,
  output logic         trig_pulse,
  output logic         trig_flag
);

  logic [W-1:0] cnt;
  logic [W-1:0] act_per;
  logic [W-1:0] act_cmp;
  logic         at_peak;
  logic         at_trough;
  logic         fire;

  pwmtrig_carrier #(.W(W)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_period (cfg_period),
    .cfg_compare(cfg_compare),
    .cnt        (cnt),
    .act_per    (act_per),
    .act_cmp    (act_cmp),
    .at_peak    (at_peak),
    .at_trough  (at_trough)
  );

  pwmtrig_compare #(.W(W)) u_compare (
    .cnt     (cnt),
    .act_cmp (act_cmp),
    .pwm_out (pwm_out)
  );

  pwmtrig_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sel    (cfg_sel),
    .conv_busy  (conv_busy),
    .flag_clr   (flag_clr),
    .at_peak    (at_peak),
    .at_trough  (at_trough),
    .fire       (fire),
    .trig_pulse (trig_pulse),
    .trig_flag  (trig_flag)
  );

endmodule

// File: rtl/pwmtrig_checker.sv
module pwmtrig_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   cfg_sel,
  input logic         conv_busy,
  input logic         flag_clr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act_per,
  input logic [W-1:0] act_cmp,
  input logic         at_peak,
  input logic         at_trough,
  input logic         fire,
  input logic         trig_pulse,
  input logic         trig_flag
);

  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_per);

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(at_trough) |-> ($stable(act_per) && $stable(act_cmp)));

  p_pulse_from_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(at_peak || at_trough));

  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> !$past(conv_busy));

  p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_sel) == 2'b00) |-> !trig_pulse);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> trig_flag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_clr) && !$past(fire)) |-> !trig_flag);

endmodule

bind pwm_sync_trigger pwmtrig_checker #(.W(W)) u_pwmtrig_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_sel    (cfg_sel),
  .conv_busy  (conv_busy),
  .flag_clr   (flag_clr),
  .cnt        (cnt),
  .act_per    (act_per),
  .act_cmp    (act_cmp),
  .at_peak    (at_peak),
  .at_trough  (at_trough),
  .fire       (fire),
  .trig_pulse (trig_pulse),
  .trig_flag  (trig_flag)
);

// File: tb/pwm_sync_trigger_bench.sv
module pwm_sync_trigger_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cfg_period = '0;
  logic [W-1:0] cfg_compare = '0;
  logic [1:0]   cfg_sel = 2'b00;
  logic         conv_busy = 1'b0;
  logic         flag_clr = 1'b0;
  logic         pwm_out;
  logic         trig_pulse;
  logic         trig_flag;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwm_sync_trigger #(.W(W)) u_pwm_sync_trigger (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_period (cfg_period),
    .cfg_compare(cfg_compare),
    .cfg_sel    (cfg_sel),
    .conv_busy  (conv_busy),
    .flag_clr   (flag_clr),
    .pwm_out    (pwm_out),
    .trig_pulse (trig_pulse),
    .trig_flag  (trig_flag)
  );

  // Phase-indexed carrier model: phase 0 is the bottom, phase mP the top,
  // one carrier spans phases 0 .. 2*mP-1.
  int   ph, mP, mC;
  logic e_trig, e_flag;

  function automatic int mcount();
    return (ph <= mP) ? ph : 2 * mP - ph;
  endfunction

  function automatic int exp_pwm();
    return (mcount() < mC) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    logic f;
    if (!rst_n) begin
      ph <= 0; mP <= 1; mC <= 0; e_trig <= 1'b0; e_flag <= 1'b0;
    end else begin
      f = ((ph == mP && cfg_sel[0]) || (ph == 0 && cfg_sel[1])) && !conv_busy;
      e_trig <= f;
      e_flag <= f || (e_flag && !flag_clr);
      if (ph == 0) begin
        mP <= (cfg_period == '0) ? 1 : int'(cfg_period);
        mC <= int'(cfg_compare);
        ph <= 1;
      end else begin
        ph <= (ph == 2 * mP - 1) ? 0 : ph + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic follow(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      chk(req, "pwm_out", int'(pwm_out), exp_pwm());
      chk(req, "trig_pulse", int'(trig_pulse), int'(e_trig));
      chk(req, "trig_flag", int'(trig_flag), int'(e_flag));
    end
  endtask

  task automatic tally(input int n, output int pulses, output int highs, output int adj);
    logic prev;
    prev = 1'b0; pulses = 0; highs = 0; adj = 0;
    repeat (n) begin
      @(negedge clk);
      if (trig_pulse) pulses++;
      if (pwm_out) highs++;
      if (trig_pulse && prev) adj++;
      prev = trig_pulse;
    end
  endtask

  task automatic set_cfg(input int p, input int c, input logic [1:0] s);
    @(negedge clk);
    cfg_period = W'(p); cfg_compare = W'(c); cfg_sel = s;
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pwm_out in reset", int'(pwm_out), 0);
    chk("R1", "trig_pulse in reset", int'(trig_pulse), 0);
    chk("R1", "trig_flag in reset", int'(trig_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "trig_flag after reset", int'(trig_flag), 0);
    chk("R1", "trig_pulse after reset", int'(trig_pulse), 0);
  endtask

  task automatic t_triangle_r2();
    int np, nh, na;
    set_cfg(4, 2, 2'b11);
    follow(24, "R2");
    tally(8, np, nh, na);
    chk("R2", "pulses per 8-cycle carrier", np, 2);
    chk("R4", "pwm high cycles, P=4 C=2", nh, 3);
    chk("R7", "adjacent pulse cycles", na, 0);
  endtask

  task automatic t_compare_r4();
    int np, nh, na;
    set_cfg(4, 0, 2'b11);
    follow(12, "R4");
    tally(8, np, nh, na);
    chk("R4", "pwm high, compare 0", nh, 0);
    set_cfg(4, 5, 2'b11);
    follow(12, "R4");
    tally(8, np, nh, na);
    chk("R4", "pwm high, compare above top", nh, 8);
    set_cfg(4, 4, 2'b11);
    follow(12, "R4");
    tally(8, np, nh, na);
    chk("R4", "pwm high, compare equals top", nh, 7);
  endtask

  task automatic t_period_change_r5();
    int gap;
    set_cfg(8, 3, 2'b01);
    follow(40, "R5");
    // mid-ramp change: must not act until the next bottom, counter stays bounded
    while (ph != 3) @(negedge clk);
    cfg_period = W'(3); cfg_compare = W'(1);
    follow(30, "R5");
    follow(12, "R3");
    while (!trig_pulse) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!trig_pulse && gap < 50);
    chk("R2", "top-to-top spacing at P=3", gap, 6);
  endtask

  task automatic t_select_r6();
    int np, nh, na;
    int want [4] = '{0, 4, 4, 8};
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      cfg_sel = 2'(s);
      @(negedge clk);
      tally(24, np, nh, na);
      chk("R6", $sformatf("pulses in 4 carriers, sel=%0d", s), np, want[s]);
    end
    follow(6, "R6");
  endtask

  task automatic t_busy_r8();
    int np, nh, na, wait_c;
    set_cfg(5, 2, 2'b11);
    follow(14, "R8");
    @(negedge clk);
    conv_busy = 1'b1;
    tally(12, np, nh, na);
    chk("R8", "pulses while busy", np, 0);
    conv_busy = 1'b0;
    wait_c = 0;
    do begin @(negedge clk); wait_c++; end while (!trig_pulse && wait_c < 20);
    chk("R8", "pulse after busy within one half carrier", (wait_c <= 6) ? 1 : 0, 1);
    follow(20, "R8");
  endtask

  task automatic t_flag_r9();
    int mism;
    set_cfg(2, 1, 2'b00);
    follow(8, "R9");
    chk("R9", "flag held with no clear", int'(trig_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9", "flag after clear", int'(trig_flag), 0);
    follow(4, "R9");
    cfg_sel = 2'b11;
    flag_clr = 1'b1;
    mism = 0;
    repeat (16) begin
      @(negedge clk);
      if (trig_flag != trig_pulse) mism++;
    end
    chk("R9", "flag vs pulse under constant clear", mism, 0);
    follow(8, "R9");
    flag_clr = 1'b0;
    follow(6, "R9");
  endtask

  task automatic t_zero_period_r2();
    int np, nh, na;
    set_cfg(0, 1, 2'b11);
    follow(8, "R2");
    tally(10, np, nh, na);
    chk("R2", "pulses with top count 0", np, 10);
    chk("R4", "pwm high with top 0, compare 1", nh, 5);
  endtask

  initial begin
    t_reset_r1();
    follow(4, "R1");
    t_triangle_r2();
    t_compare_r4();
    t_period_change_r5();
    t_select_r6();
    t_busy_r8();
    t_flag_r9();
    t_zero_period_r2();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule